// File: doc/BRIEF.md
# Dual Alarm Match and Interrupt Unit

This block watches a running calendar time and compares it against two programmable alarm settings. Each alarm holds one value for every time field, together with a per-field match mask. A field whose mask bit is clear always counts as matching. This gives hourly, daily or coarser repetition without any extra logic. Matches are evaluated only in the cycle that carries the once-per-second time-update strobe, so one matching second produces exactly one event.

A shared mode input selects between two behaviours. In single-event mode, each armed alarm sets its own sticky status flag once per arming, and the interrupt line stays high while any flag is set. In repeating mode, every matching strobe produces a one-cycle interrupt pulse. If both alarms are enabled in repeating mode, alarm 0 takes precedence and alarm 1 is ignored. A status-read strobe clears both flags. A flag that is being set in the same cycle is kept, so no event is lost. While the frequency-output enable is high, neither alarm acts.

Top module: `dual_alarm_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both status flags and the interrupt output are 0.
- R2: Field f of a time or alarm value occupies bits [f*FIELD_W +: FIELD_W]. An alarm matches when every field whose mask bit is 1 equals the corresponding current-time field; fields with mask bit 0 always match. A match counts only in a cycle where the time-update strobe is 1.
- R3: An alarm acts only while its enable input is 1 and the frequency-output enable is 0. Otherwise a match leaves its flag and the interrupt unchanged.
- R4: In single-event mode (mode input 0), a match sets the alarm's flag one clock after the strobe. The alarm then ignores further matches until its enable has been 0 for at least one clock.
- R5: In single-event mode both alarms may be armed at once. Each sets only its own flag, so flag0 and flag1 show which alarm fired.
- R6: A status-read strobe clears both flags on the next clock.
- R7: If an alarm fires in the same cycle as a status-read strobe, its flag is 1 afterwards.
- R8: In repeating mode (mode input 1), each matching strobe sets the firing alarm's flag and drives the interrupt high for exactly one cycle, starting one clock after the strobe.
- R9: In repeating mode with both enables at 1, alarm 1 neither sets its flag nor produces an interrupt.
- R10: In single-event mode the interrupt output equals the OR of the two flags.
- R11: Repeating interrupts continue on every match until the enable is cleared or the mode input returns to 0. After a return to single-event mode, the alarm fires once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle time-update strobe |
| now_i | input | NUM_FIELDS*FIELD_W | Current time fields |
| alm0_val_i | input | NUM_FIELDS*FIELD_W | Alarm 0 field values |
| alm0_mask_i | input | NUM_FIELDS | Alarm 0 per-field match enables |
| alm1_val_i | input | NUM_FIELDS*FIELD_W | Alarm 1 field values |
| alm1_mask_i | input | NUM_FIELDS | Alarm 1 per-field match enables |
| alm0_en_i | input | 1 | Alarm 0 enable |
| alm1_en_i | input | 1 | Alarm 1 enable |
| rep_mode_i | input | 1 | 0 = single-event, 1 = repeating |
| fout_en_i | input | 1 | Frequency-output enable; blocks alarms when 1 |
| stat_rd_i | input | 1 | Status-read strobe; clears flags |
| flag0_o | output | 1 | Alarm 0 sticky status flag |
| flag1_o | output | 1 | Alarm 1 sticky status flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest state to reach from the ports is the "spent" condition of a single-event alarm. It is invisible at the outputs and can only be inferred from a second matching strobe that does nothing. To cover it, the bench fires an alarm, reads the status, and strobes the same time again. It then drops and restores the enable and checks that the alarm fires once more. The field comparison is covered by a full sweep of every alarm value, mask and current time in a two-field, two-bit configuration, with each alarm armed alone. In that sweep the other alarm is left with an all-clear mask, so it matches every time but stays disabled.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALM_CNT = 2;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_REPEAT = 1'b1
  } alm_mode_e;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int NUM_FIELDS = 6,
  parameter int FIELD_W    = 8,
  localparam int TIME_W    = NUM_FIELDS * FIELD_W
) (
  input  logic [TIME_W-1:0]     now_i,
  input  logic [TIME_W-1:0]     alarm_i,
  input  logic [NUM_FIELDS-1:0] mask_i,
  output logic                  match_o
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    assign fld_ok[f] = ~mask_i[f] |
                       (now_i[f*FIELD_W +: FIELD_W] == alarm_i[f*FIELD_W +: FIELD_W]);
  end

  assign match_o = &fld_ok;
endmodule

// File: rtl/alm_arbiter.sv
module alm_arbiter
  import alm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  alm_mode_e          mode_i,
  input  logic               fout_en_i,
  input  logic [ALM_CNT-1:0] en_i,
  input  logic [ALM_CNT-1:0] match_i,
  output logic [ALM_CNT-1:0] fire_o
);
  for (genvar k = 0; k < ALM_CNT; k++) begin : g_alm
    logic spent_q;
    logic outranked;

    if (k == 0) begin : g_top
      assign outranked = 1'b0;
    end else begin : g_low
      assign outranked = |en_i[k-1:0];
    end

    assign fire_o[k] = tick_i & en_i[k] & ~fout_en_i & match_i[k] &
                       ((mode_i == MODE_REPEAT) ? ~outranked : ~spent_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        spent_q <= 1'b0;
      end else if (!en_i[k] || mode_i == MODE_REPEAT) begin
        spent_q <= 1'b0;
      end else if (fire_o[k]) begin
        spent_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/alm_status.sv
module alm_status
  import alm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  alm_mode_e          mode_i,
  input  logic [ALM_CNT-1:0] fire_i,
  input  logic               stat_rd_i,
  output logic [ALM_CNT-1:0] flag_o,
  output logic               irq_o
);
  logic [ALM_CNT-1:0] flag_q, flag_nxt;
  logic               irq_q, irq_nxt;

  always_comb begin
    flag_nxt = fire_i | (flag_q & ~{ALM_CNT{stat_rd_i}});
    irq_nxt  = (mode_i == MODE_REPEAT) ? |fire_i : |flag_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= irq_nxt;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import alm_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int FIELD_W    = 8,
  localparam int TIME_W    = NUM_FIELDS * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic [TIME_W-1:0]     now_i,
  input  logic [TIME_W-1:0]     alm0_val_i,
  input  logic [NUM_FIELDS-1:0] alm0_mask_i,
  input  logic [TIME_W-1:0]     alm1_val_i,
  input  logic [NUM_FIELDS-1:0] alm1_mask_i,
  input  logic                  alm0_en_i,
  input  logic                  alm1_en_i,
  input  logic                  rep_mode_i,
  input  logic                  fout_en_i,
  input  logic                  stat_rd_i,
  output logic                  flag0_o,
  output logic                  flag1_o,
  output logic                  irq_o
);
  logic [TIME_W-1:0]     val_arr  [ALM_CNT];
  logic [NUM_FIELDS-1:0] mask_arr [ALM_CNT];
  logic [ALM_CNT-1:0]    alm_match;
  logic [ALM_CNT-1:0]    alm_fire;
  logic [ALM_CNT-1:0]    alm_flag;
  alm_mode_e             mode;

  assign val_arr[0]  = alm0_val_i;
  assign val_arr[1]  = alm1_val_i;
  assign mask_arr[0] = alm0_mask_i;
  assign mask_arr[1] = alm1_mask_i;
  assign mode        = alm_mode_e'(rep_mode_i);

  for (genvar k = 0; k < ALM_CNT; k++) begin : g_cmp
    alm_field_cmp #(
      .NUM_FIELDS(NUM_FIELDS),
      .FIELD_W   (FIELD_W)
    ) u_cmp (
      .now_i  (now_i),
      .alarm_i(val_arr[k]),
      .mask_i (mask_arr[k]),
      .match_o(alm_match[k])
    );
  end

  alm_arbiter u_arb (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .mode_i   (mode),
    .fout_en_i(fout_en_i),
    .en_i     ({alm1_en_i, alm0_en_i}),
    .match_i  (alm_match),
    .fire_o   (alm_fire)
  );

  alm_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .fire_i   (alm_fire),
    .stat_rd_i(stat_rd_i),
    .flag_o   (alm_flag),
    .irq_o    (irq_o)
  );

  assign flag0_o = alm_flag[0];
  assign flag1_o = alm_flag[1];
endmodule

// File: rtl/dual_alarm_unit_chk.sv
module dual_alarm_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       rep_mode_i,
  input logic       fout_en_i,
  input logic       alm0_en_i,
  input logic       alm1_en_i,
  input logic       stat_rd_i,
  input logic       flag0_o,
  input logic       flag1_o,
  input logic       irq_o,
  input logic [1:0] alm_match,
  input logic [1:0] alm_fire
);
  // R2
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> !$rose(flag0_o) && !$rose(flag1_o));

  // R3
  fout_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fout_en_i |=> !$rose(flag0_o) && !$rose(flag1_o));

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd_i && !tick_i |=> !flag0_o && !flag1_o);

  // R7
  set_wins0_chk: assert property (@(posedge clk) disable iff (rst)
    alm_fire[0] |=> flag0_o);

  // R7
  set_wins1_chk: assert property (@(posedge clk) disable iff (rst)
    alm_fire[1] |=> flag1_o);

  // R8
  rep_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rep_mode_i && $past(rep_mode_i) && irq_o |-> $past(tick_i));

  // R9
  override_chk: assert property (@(posedge clk) disable iff (rst)
    rep_mode_i && alm0_en_i && alm1_en_i && tick_i && !alm_match[0] |=> !irq_o);

  // R10
  single_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !rep_mode_i |=> irq_o == (flag0_o | flag1_o));
endmodule

bind dual_alarm_unit dual_alarm_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_i    (tick_i),
  .rep_mode_i(rep_mode_i),
  .fout_en_i (fout_en_i),
  .alm0_en_i (alm0_en_i),
  .alm1_en_i (alm1_en_i),
  .stat_rd_i (stat_rd_i),
  .flag0_o   (flag0_o),
  .flag1_o   (flag1_o),
  .irq_o     (irq_o),
  .alm_match (alm_match),
  .alm_fire  (alm_fire)
);

// File: tb/dual_alarm_unit_bench.sv
module dual_alarm_unit_bench;
  localparam int NF = 2;
  localparam int FW = 2;
  localparam int TW = NF * FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [TW-1:0] now = '0;
  logic [TW-1:0] a0_val = '0, a1_val = '0;
  logic [NF-1:0] a0_mask = '0, a1_mask = '0;
  logic          a0_en = 1'b0, a1_en = 1'b0;
  logic          rep = 1'b0, fout = 1'b0, rd = 1'b0;
  logic          flag0, flag1, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dual_alarm_unit #(.NUM_FIELDS(NF), .FIELD_W(FW)) u_dual_alarm_unit (
    .clk(clk), .rst(rst), .tick_i(tick), .now_i(now),
    .alm0_val_i(a0_val), .alm0_mask_i(a0_mask),
    .alm1_val_i(a1_val), .alm1_mask_i(a1_mask),
    .alm0_en_i(a0_en), .alm1_en_i(a1_en), .rep_mode_i(rep),
    .fout_en_i(fout), .stat_rd_i(rd),
    .flag0_o(flag0), .flag1_o(flag1), .irq_o(irq)
  );

  function automatic logic exp_match(int alm, int mask, int t);
    for (int f = 0; f < NF; f++) begin
      int div = 1 << (f * FW);
      if (((mask >> f) & 1) == 1 && ((alm / div) % (1 << FW)) != ((t / div) % (1 << FW)))
        return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_at(int t);
    now  = TW'(t);
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic read_stat();
    rd = 1'b1;
    step();
    rd = 1'b0;
  endtask

  task automatic disarm();
    a0_en = 1'b0;
    a1_en = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1 flag0 in reset", flag0, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    rst = 1'b0;
    step();
    chk("R1 flag0 after reset", flag0, 1'b0);
    chk("R1 flag1 after reset", flag1, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);

    // R2 R3 R5 R10: full sweep, single-event mode, each alarm alone
    for (int k = 0; k < 2; k++) begin
      for (int m = 0; m < (1 << NF); m++) begin
        for (int a = 0; a < (1 << TW); a++) begin
          for (int t = 0; t < (1 << TW); t++) begin
            logic e;
            e = exp_match(a, m, t);
            disarm();
            if (k == 0) begin
              a0_val = TW'(a); a0_mask = NF'(m); a1_mask = '0; a0_en = 1'b1;
            end else begin
              a1_val = TW'(a); a1_mask = NF'(m); a0_mask = '0; a1_en = 1'b1;
            end
            tick_at(t);
            chk("R2 own flag", (k == 0) ? flag0 : flag1, e);
            chk("R3 disabled alarm flag", (k == 0) ? flag1 : flag0, 1'b0);
            chk("R10 irq level", irq, e);
            read_stat();
            chk("R6 flags cleared", flag0 | flag1, 1'b0);
          end
        end
      end
    end

    a0_val = 4'h5; a0_mask = 2'b11;
    a1_val = 4'hA; a1_mask = 2'b11;

    // R4: one fire per arming
    disarm();
    a0_en = 1'b1;
    tick_at(5);
    chk("R4 first match", flag0, 1'b1);
    read_stat();
    tick_at(5);
    chk("R4 second match ignored", flag0, 1'b0);
    chk("R4 irq stays low", irq, 1'b0);
    disarm();
    a0_en = 1'b1;
    tick_at(5);
    chk("R4 re-armed fires", flag0, 1'b1);
    read_stat();

    // R5: both armed together
    a1_val = 4'h5;
    disarm();
    a0_en = 1'b1; a1_en = 1'b1;
    tick_at(5);
    chk("R5 flag0", flag0, 1'b1);
    chk("R5 flag1", flag1, 1'b1);
    read_stat();
    chk("R6 both cleared", flag0 | flag1, 1'b0);

    // R3: frequency output blocks alarms
    disarm();
    a0_en = 1'b1; fout = 1'b1;
    tick_at(5);
    chk("R3 fout blocks flag", flag0, 1'b0);
    chk("R3 fout blocks irq", irq, 1'b0);
    fout = 1'b0;

    // R2: no strobe, no match
    now = 4'h5;
    step();
    chk("R2 no strobe", flag0, 1'b0);
    tick_at(5);
    chk("R2 strobe fires", flag0, 1'b1);
    read_stat();

    // R7: set beats read
    disarm();
    a0_en = 1'b1; now = 4'h5; tick = 1'b1; rd = 1'b1;
    step();
    tick = 1'b0; rd = 1'b0;
    chk("R7 set wins", flag0, 1'b1);
    read_stat();

    // R8: repeating pulses
    disarm();
    rep = 1'b1; a0_en = 1'b1;
    tick_at(5);
    chk("R8 irq pulse", irq, 1'b1);
    chk("R8 flag set", flag0, 1'b1);
    step();
    chk("R8 pulse one cycle", irq, 1'b0);
    tick_at(5);
    chk("R8 repeat pulse", irq, 1'b1);
    step();
    chk("R8 repeat ends", irq, 1'b0);
    tick_at(6);
    chk("R8 no match no pulse", irq, 1'b0);
    read_stat();

    // R9: alarm 0 overrides alarm 1
    a1_val = 4'h6;
    a0_en = 1'b1; a1_en = 1'b1;
    tick_at(6);
    chk("R9 override irq", irq, 1'b0);
    chk("R9 override flag1", flag1, 1'b0);
    a0_en = 1'b0;
    tick_at(6);
    chk("R9 alarm1 alone irq", irq, 1'b1);
    chk("R9 alarm1 alone flag", flag1, 1'b1);
    read_stat();

    // R11: stopping repeating mode
    a0_en = 1'b1; a1_en = 1'b0;
    tick_at(5);
    chk("R11 running", irq, 1'b1);
    read_stat();
    a0_en = 1'b0;
    tick_at(5);
    chk("R11 enable cleared irq", irq, 1'b0);
    chk("R11 enable cleared flag", flag0, 1'b0);
    a0_en = 1'b1; rep = 1'b0;
    tick_at(5);
    chk("R11 back to single fires", flag0, 1'b1);
    step();
    chk("R10 irq held by flag", irq, 1'b1);
    read_stat();
    chk("R10 irq drops on read", irq, 1'b0);
    tick_at(5);
    chk("R11 single fires once", flag0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule